// File: doc/BRIEF.md
# Three-Decade Decimal Event Counter with Holding Latches

The block counts events on a single-bit count input and keeps the running total as three binary-coded decimal digits: units, tens and hundreds, from 000 to 999. A high-to-low transition on the count input adds one. The count input comes from the system clock domain. The block samples it through a short flip-flop chain and finds the falling edge there. All three digits then update together in one system clock cycle, so no carry ripples from one decade to the next.

A hold input stops counting and keeps the present total. An active-high clear input sets all three digits to zero. A latch-enable input controls a 4-bit holding register per digit. While latch-enable is low, the outputs follow the live count. While it is high, they show the total that was present when it rose, whatever the counter does, and a clear does not change them. The wrap output pulses once per thousand counts, so a second instance can count thousands.

Top module: `decade_tally`

## Requirements
- R1: While the active-low system reset `rst_n` is asserted, and right after it is released, `heldBcd` reads 000 and `wrapPulse` is low.
- R2: Each decade counts 0 to 9 and returns to 0. A decade steps only when every lower decade wraps from 9 to 0 on the same event. All three decades change in the same clock cycle. `heldBcd[3:0]` holds the units, `[7:4]` the tens and `[11:8]` the hundreds, each as plain BCD.
- R3: Each high-to-low transition of `countIn` adds exactly one to the count. The new total is visible at most three rising clock edges after `countIn` is first sampled low. A low-to-high transition changes nothing.
- R4: While `countHold` is high, falling edges of `countIn` are ignored and the count keeps its value.
- R5: While `masterClear` is high, all three decades go to zero on the next rising clock edge. It overrides both counting and hold, and a falling edge that arrives during a clear is lost.
- R6: While `latchEn` is low, `heldBcd` shows the live count.
- R7: While `latchEn` stays high, `heldBcd` keeps the count that was present when `latchEn` rose, whatever happens on `countIn`.
- R8: A clear applied while `latchEn` is high leaves `heldBcd` unchanged. Once `latchEn` falls, `heldBcd` shows the cleared count.
- R9: `wrapPulse` is high for exactly one clock cycle each time the count wraps from 999 to 000, which gives one pulse per 1000 counts. In that same cycle the count reads 000. It is low at all other times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low system reset |
| countIn | input | 1 | Event input, already synchronous to clk; a falling edge counts |
| countHold | input | 1 | High blocks counting and keeps the total |
| masterClear | input | 1 | High clears all decades; the holding registers are not affected |
| latchEn | input | 1 | Low: outputs follow the count; high: outputs are frozen |
| heldBcd | output | 12 | Three BCD digits, hundreds in the top nibble |
| wrapPulse | output | 1 | One-cycle pulse on each 999 to 000 wrap |

## Verification
The embedded properties check the following on every cycle. Each digit stays at or below nine. The count does not move unless an advance or clear strobe is present. A clear yields 000. A falling edge never gives two advances in a row. The wrap pulse lasts one cycle and coincides with 000. Frozen outputs stay still while latch-enable stays high. Only the bench scenarios can show that the total matches an integer modulo-1000 model across a full 2000-event run with carries. They also show that hold drops events, that the frozen value is the one present when latch-enable rose and survives a clear, that an edge arriving during a clear is lost, and that exactly two wrap pulses appear over two thousand events.

// File: rtl/tally_pkg.sv
package tally_pkg;
  // Strobes sent from the control half to the datapath half
  typedef struct packed {
    logic advance;  // one qualified count event this cycle
    logic clear;    // zero all decades
    logic track;    // holding registers follow the count
  } tally_strobe_t;
endpackage

// File: rtl/tally_ctrl.sv
import tally_pkg::*;

module tally_ctrl #(
  parameter int SYNC_DEPTH = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          countIn,
  input  logic          countHold,
  input  logic          masterClear,
  input  logic          latchEn,
  output tally_strobe_t stb
);
  localparam int CHAIN_W = SYNC_DEPTH + 1;

  // Sample chain; the oldest bit is one stage behind the newest synced bit
  logic [CHAIN_W-1:0] sampleQ;
  logic               fallSeen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sampleQ <= '1;
    else        sampleQ <= {sampleQ[CHAIN_W-2:0], countIn};
  end

  assign fallSeen = sampleQ[CHAIN_W-1] & ~sampleQ[CHAIN_W-2];

  always_comb begin
    stb.clear   = masterClear;
    stb.advance = fallSeen & ~countHold & ~masterClear;
    stb.track   = ~latchEn;
  end

  // R3: one falling edge gives a single advance, never two in a row
  a_r3_single_advance: assert property (@(posedge clk) disable iff (!rst_n)
    stb.advance |=> !stb.advance);

  // R4: hold blocks every advance strobe
  a_r4_hold_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    countHold |-> !stb.advance);
endmodule

// File: rtl/tally_datapath.sv
import tally_pkg::*;

module tally_datapath #(
  parameter int DECADES = 3,
  parameter int DIGIT_W = 4,
  parameter int RADIX   = 10
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  tally_strobe_t              stb,
  output logic [DECADES*DIGIT_W-1:0] heldBcd,
  output logic                       wrapPulse
);
  localparam int TOTAL_W = DECADES * DIGIT_W;
  localparam logic [DIGIT_W-1:0] TOP_DIGIT = DIGIT_W'(RADIX - 1);

  logic [DECADES-1:0][DIGIT_W-1:0] digitQ;
  logic [DECADES-1:0][DIGIT_W-1:0] digitNext;
  logic [DECADES-1:0]              atTop;
  logic [DECADES:0]                carryIn;
  logic [TOTAL_W-1:0]              liveFlat;
  logic [TOTAL_W-1:0]              heldQ;

  assign carryIn[0] = stb.advance;

  for (genvar g = 0; g < DECADES; g++) begin : g_decade
    assign atTop[g]       = (digitQ[g] == TOP_DIGIT);
    assign carryIn[g + 1] = carryIn[g] & atTop[g];

    always_comb begin
      if (stb.clear)       digitNext[g] = '0;
      else if (carryIn[g]) digitNext[g] = atTop[g] ? '0 : digitQ[g] + DIGIT_W'(1);
      else                 digitNext[g] = digitQ[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) digitQ[g] <= '0;
      else        digitQ[g] <= digitNext[g];
    end

    // R2: a decade never leaves the range 0..RADIX-1
    a_r2_digit_range: assert property (@(posedge clk) disable iff (!rst_n)
      digitQ[g] <= TOP_DIGIT);
  end

  assign liveFlat = digitQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      heldQ     <= '0;
      wrapPulse <= 1'b0;
    end else begin
      if (stb.track) heldQ <= digitNext;
      wrapPulse <= carryIn[DECADES] & ~stb.clear;
    end
  end

  assign heldBcd = stb.track ? liveFlat : heldQ;

  // R3/R4: without a strobe the count cannot move
  a_r4_count_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!stb.advance && !stb.clear) |=> $stable(digitQ));

  // R5: a clear always leaves zero behind
  a_r5_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    stb.clear |=> (digitQ == '0));

  // R9: wrap pulse lasts one cycle and lines up with a zero count
  a_r9_wrap_single: assert property (@(posedge clk) disable iff (!rst_n)
    wrapPulse |=> !wrapPulse);
  a_r9_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    wrapPulse |-> (digitQ == '0));
endmodule

// File: rtl/decade_tally.sv
import tally_pkg::*;

module decade_tally #(
  parameter int DECADES    = 3,
  parameter int DIGIT_W    = 4,
  parameter int RADIX      = 10,
  parameter int SYNC_DEPTH = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       countIn,
  input  logic                       countHold,
  input  logic                       masterClear,
  input  logic                       latchEn,
  output logic [DECADES*DIGIT_W-1:0] heldBcd,
  output logic                       wrapPulse
);
  tally_strobe_t stb;

  tally_ctrl #(.SYNC_DEPTH(SYNC_DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .countIn(countIn), .countHold(countHold),
    .masterClear(masterClear), .latchEn(latchEn), .stb(stb)
  );

  tally_datapath #(.DECADES(DECADES), .DIGIT_W(DIGIT_W), .RADIX(RADIX)) u_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb), .heldBcd(heldBcd), .wrapPulse(wrapPulse)
  );

  // R7/R8: frozen outputs stay put while latch-enable remains high
  a_r7_latch_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (latchEn && $past(latchEn)) |-> $stable(heldBcd));
endmodule

// File: tb/decade_tally_bench.sv
`timescale 1ns/1ps
module decade_tally_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        countIn = 1'b1;
  logic        countHold = 1'b0;
  logic        masterClear = 1'b0;
  logic        latchEn = 1'b0;
  logic [11:0] heldBcd;
  logic        wrapPulse;

  int checks = 0;
  int errors = 0;
  int model = 0;
  int heldModel = 0;
  int wrapSeen = 0;
  bit done = 1'b0;

  typedef struct { int value; string tag; } exp_t;
  exp_t expQ[$];

  always #2.5 clk = ~clk;

  decade_tally u_decade_tally (
    .clk(clk), .rst_n(rst_n), .countIn(countIn), .countHold(countHold),
    .masterClear(masterClear), .latchEn(latchEn), .heldBcd(heldBcd),
    .wrapPulse(wrapPulse)
  );

  function automatic logic [11:0] toBcd(int v);
    return {4'(v / 100), 4'((v / 10) % 10), 4'(v % 10)};
  endfunction

  task automatic check(bit ok, string tag, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  // Driver side: push the value the outputs should show
  task automatic pushExp(string tag);
    exp_t e;
    if (!latchEn) heldModel = model;
    e.value = latchEn ? heldModel : model;
    e.tag = tag;
    expQ.push_back(e);
  endtask

  // Monitor: pop and compare once per cycle away from the rising edge
  initial forever begin
    @(negedge clk);
    if (expQ.size() > 0) begin
      exp_t e;
      e = expQ.pop_front();
      check(heldBcd == toBcd(e.value), e.tag, int'(heldBcd), int'(toBcd(e.value)));
    end
  end

  always @(negedge clk) if (rst_n && wrapPulse) wrapSeen++;

  task automatic pulse(string tag);
    @(negedge clk); countIn = 1'b0;
    repeat (4) @(negedge clk);
    countIn = 1'b1;
    repeat (4) @(negedge clk);
    if (!countHold && !masterClear) model = (model + 1) % 1000;
    pushExp(tag);
  endtask

  task automatic drain;
    while (expQ.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check(heldBcd == 12'h000, "R1 reset digits", int'(heldBcd), 0);
    check(wrapPulse == 1'b0, "R1 reset wrap", int'(wrapPulse), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(heldBcd == 12'h000, "R1 after release", int'(heldBcd), 0);

    // R3: a falling edge counts once; the rise that follows adds nothing
    @(negedge clk); countIn = 1'b0;
    repeat (4) @(negedge clk);
    check(heldBcd == 12'h001, "R3 falling edge", int'(heldBcd), 1);
    countIn = 1'b1;
    repeat (4) @(negedge clk);
    check(heldBcd == 12'h001, "R3 rising edge ignored", int'(heldBcd), 1);
    model = 1;

    for (int i = 0; i < 11; i++) pulse("R2 R3 units/tens");
    drain();

    // R4: hold drops events
    countHold = 1'b1;
    for (int i = 0; i < 3; i++) pulse("R4 hold keeps count");
    countHold = 1'b0;
    drain();

    // R6/R7: freeze, count on, then release
    for (int i = 0; i < 25; i++) pulse("R2 R6 live");
    @(negedge clk); latchEn = 1'b1;
    for (int i = 0; i < 5; i++) pulse("R7 frozen");
    drain();
    latchEn = 1'b0;
    @(negedge clk); pushExp("R6 released shows live");
    drain();

    // R8: clear while frozen
    latchEn = 1'b1;
    @(negedge clk); masterClear = 1'b1;
    repeat (2) @(negedge clk);
    masterClear = 1'b0; model = 0;
    @(negedge clk); pushExp("R8 frozen across clear");
    drain();
    latchEn = 1'b0;
    @(negedge clk); pushExp("R5 R8 cleared after release");
    drain();

    // R5: clear overrides a falling edge and hold
    for (int i = 0; i < 7; i++) pulse("R2 pre-clear");
    @(negedge clk); countIn = 1'b0; masterClear = 1'b1; countHold = 1'b1;
    repeat (4) @(negedge clk);
    masterClear = 1'b0; countHold = 1'b0; countIn = 1'b1;
    repeat (4) @(negedge clk);
    model = 0; pushExp("R5 clear beats edge");
    drain();

    // R2/R9: run through two wraps
    wrapSeen = 0;
    while (model != 999) pulse("R2 carry run");
    drain();
    check(wrapSeen == 0, "R9 no early wrap", wrapSeen, 0);
    pulse("R2 R9 999 to 000");
    drain();
    check(wrapSeen == 1, "R9 first wrap", wrapSeen, 1);
    for (int i = 0; i < 1000; i++) pulse("R2 second thousand");
    drain();
    check(wrapSeen == 2, "R9 second wrap", wrapSeen, 2);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule